// File: doc/BRIEF.md
# Twin-Unit Comparison Self-Test Controller

This block runs a built-in self-test over two copies of the same small combinational network. A binary counter walks through every input combination, and the same pattern reaches both copies in the same cycle. The analyser XORs the two output vectors and sets a sticky fail flag on the first disagreement. No stored signature is involved: each copy serves as the reference for the other.

To show that the comparison finds real defects, one copy can carry a modelled interconnect fault during a run. The fault can be a stuck-at-0, a stuck-at-1, a short between two lines or an open line. A fault-select word chooses the copy, the fault kind and the lines involved. The word is taken in when a run starts. A run begins with a start pulse, keeps busy high while patterns are applied, and ends with a one-cycle done pulse. The fail flag then holds the verdict until the next start or reset.

Each copy has PAT_W input lines. Output bit 0 is the parity of the lines as seen at their far ends. Output bit j (j ≥ 1) is the AND of near-end lines (j−1) mod PAT_W and j mod PAT_W.

Top module: `twin_cmp_bist`

## Requirements
- R1: When start is high while the block is idle, the next clock edge sets busy to 1, clears fail to 0 and loads pattern 0.
- R2: Busy stays high for exactly 2^PAT_W cycles after the start edge. In the cycle after the last pattern, busy is 0 and done is 1. Done is high for exactly one cycle.
- R3: A start pulse while busy is high is ignored: the count is not restarted and the run length does not change.
- R4: Patterns are applied in ascending binary order, pattern p in the p-th cycle after the start edge. The comparison for pattern p reaches fail at the following edge, so fail first reads 1 p+1 cycles after the start edge.
- R5: Fail is set when any output bit of the two units differs during a run. It then stays 1 until reset or a new accepted start, including after done.
- R6: With fault kind 0 (none), the two units always agree and fail stays 0 for the whole run.
- R7: Fault kind 1 forces line A of the selected unit to 0 at both ends. Kind 2 forces it to 1.
- R8: Fault kind 3 shorts lines A and B as a wired-AND: both lines carry the AND of their driven values at both ends.
- R9: Fault kind 4 opens line A: its far end (parity tap) reads 0, while its near end (AND taps) keeps the driven value.
- R10: fault_sel bit [FS_W−1] picks the faulty unit (0 = unit A, 1 = unit B). The other unit stays fault-free.
- R11: fault_sel is captured at the accepted start. Changes during a run have no effect on that run.
- R12: Kinds 5 to 7, a line index ≥ PAT_W, or a short with A equal to B inject no fault.
- R13: After reset, busy, done and fail are all 0.

fault_sel layout: [FS_W−1] unit, [FS_W−2:FS_W−4] kind, [2·LW−1:LW] line A, [LW−1:0] line B, where LW = clog2(PAT_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| fault_sel | input | FS_W | Unit, fault kind and line indices |
| busy | output | 1 | Patterns are being applied |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky disagreement flag |

## Verification
The bench builds the block with PAT_W=4 and OUT_W=3. A run is then only 16 patterns, every line index in the two-bit fields names a real line, and every output term, parity and both AND pairs, can be reached. These values let each fault kind be placed on the lowest and highest line and on either unit. The exact cycle of the first detection can be predicted from the bench's own model of the network. Restarts and fault-select changes part-way through a run also fit inside the short pattern window.

// File: rtl/twin_bist_pkg.sv
package twin_bist_pkg;
  localparam logic [2:0] FK_NONE  = 3'd0;
  localparam logic [2:0] FK_SA0   = 3'd1;
  localparam logic [2:0] FK_SA1   = 3'd2;
  localparam logic [2:0] FK_SHORT = 3'd3;
  localparam logic [2:0] FK_OPEN  = 3'd4;

  // width of the fault-select word for a given number of lines
  function automatic int fsel_width(input int lines);
    return 4 + 2 * $clog2(lines);
  endfunction

  // kinds above FK_OPEN carry no fault
  function automatic logic kind_known(input logic [2:0] k);
    return (k != FK_NONE) && (k <= FK_OPEN);
  endfunction
endpackage

// File: rtl/twin_bist_patgen.sv
module twin_bist_patgen #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         accept,
  output logic         last,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] pat
);
  logic [W-1:0] cnt;
  logic         busy_q;
  logic         done_q;

  assign accept = start && !busy_q;
  assign last   = busy_q && (cnt == {W{1'b1}});
  assign busy   = busy_q;
  assign done   = done_q;
  assign pat    = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        cnt    <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt <= cnt + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  a_r1_start_loads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_q && cnt == '0));
  a_r2_last_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (!busy_q && done_q));
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && cnt == W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/twin_bist_unit.sv
module twin_bist_unit
  import twin_bist_pkg::*;
#(
  parameter int W     = 4,
  parameter int OUT_W = 3,
  parameter int LW    = 2
) (
  input  logic [W-1:0]     pat,
  input  logic             inj_en,
  input  logic [2:0]       kind,
  input  logic [LW-1:0]    idx_a,
  input  logic [LW-1:0]    idx_b,
  output logic [OUT_W-1:0] out
);
  logic [W-1:0] near_v;
  logic [W-1:0] far_v;
  logic         a_ok, b_ok, bit_a, bit_b, wired;

  // safe read of a line chosen by a runtime index
  function automatic logic pick(input logic [W-1:0] v, input logic [LW-1:0] i);
    logic r;
    r = 1'b0;
    for (int k = 0; k < W; k++) if (i == LW'(k)) r = v[k];
    return r;
  endfunction

  assign a_ok  = (32'(idx_a) < W);
  assign b_ok  = (32'(idx_b) < W);
  assign bit_a = pick(pat, idx_a);
  assign bit_b = pick(pat, idx_b);
  assign wired = bit_a & bit_b;

  always_comb begin
    near_v = pat;
    far_v  = pat;
    if (inj_en && a_ok) begin
      for (int i = 0; i < W; i++) begin
        unique case (kind)
          FK_SA0: if (idx_a == LW'(i)) begin near_v[i] = 1'b0; far_v[i] = 1'b0; end
          FK_SA1: if (idx_a == LW'(i)) begin near_v[i] = 1'b1; far_v[i] = 1'b1; end
          FK_SHORT:
            if (b_ok && idx_a != idx_b && (idx_a == LW'(i) || idx_b == LW'(i))) begin
              near_v[i] = wired;
              far_v[i]  = wired;
            end
          FK_OPEN: if (idx_a == LW'(i)) far_v[i] = 1'b0;
          default: ;
        endcase
      end
    end
  end

  for (genvar j = 0; j < OUT_W; j++) begin : g_out
    if (j == 0) begin : g_par
      assign out[j] = ^far_v;
    end else begin : g_and
      assign out[j] = near_v[(j-1) % W] & near_v[j % W];
    end
  end

  always_comb begin
    if (!inj_en) a_r6_clean_lines: assert (near_v == pat && far_v == pat);
  end
endmodule

// File: rtl/twin_bist_ora.sv
module twin_bist_ora #(
  parameter int OUT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic [OUT_W-1:0] resp_a,
  input  logic [OUT_W-1:0] resp_b,
  output logic             mismatch,
  output logic             fail
);
  logic [OUT_W-1:0] diff;
  logic             fail_q;

  assign diff     = resp_a ^ resp_b;
  assign mismatch = |diff;
  assign fail     = fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      fail_q <= 1'b0;
    else if (clear)  fail_q <= 1'b0;
    else if (sample && mismatch) fail_q <= 1'b1;
  end

  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clear) |=> fail_q);
  a_r5_detect: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && mismatch && !clear) |=> fail_q);
  a_r1_clear_fail: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !fail_q);
endmodule

// File: rtl/twin_cmp_bist.sv
module twin_cmp_bist
  import twin_bist_pkg::*;
#(
  parameter  int PAT_W = 4,
  parameter  int OUT_W = 3,
  localparam int LW    = $clog2(PAT_W),
  localparam int FS_W  = 4 + 2 * LW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [FS_W-1:0] fault_sel,
  output logic            busy,
  output logic            done,
  output logic            fail
);
  logic [FS_W-1:0]  fs_q;
  logic             accept, last;
  logic [PAT_W-1:0] pat;
  logic [OUT_W-1:0] resp_a, resp_b;
  logic             mismatch;
  logic             fs_unit;
  logic [2:0]       fs_kind;
  logic [LW-1:0]    fs_a, fs_b;
  logic             inj_any;

  initial begin
    if (PAT_W < 2) $error("PAT_W must be at least 2");
    if (fsel_width(PAT_W) != FS_W) $error("fault-select width mismatch");
  end

  assign fs_unit = fs_q[FS_W-1];
  assign fs_kind = fs_q[FS_W-2 -: 3];
  assign fs_a    = fs_q[2*LW-1 -: LW];
  assign fs_b    = fs_q[LW-1:0];
  assign inj_any = kind_known(fs_kind);

  always_ff @(posedge clk) begin
    if (!rst_n)      fs_q <= '0;
    else if (accept) fs_q <= fault_sel;
  end

  twin_bist_patgen #(.W(PAT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .last(last),
    .busy(busy), .done(done), .pat(pat)
  );

  twin_bist_unit #(.W(PAT_W), .OUT_W(OUT_W), .LW(LW)) u_unit_a (
    .pat(pat), .inj_en(inj_any && !fs_unit), .kind(fs_kind),
    .idx_a(fs_a), .idx_b(fs_b), .out(resp_a)
  );

  twin_bist_unit #(.W(PAT_W), .OUT_W(OUT_W), .LW(LW)) u_unit_b (
    .pat(pat), .inj_en(inj_any && fs_unit), .kind(fs_kind),
    .idx_a(fs_a), .idx_b(fs_b), .out(resp_b)
  );

  twin_bist_ora #(.OUT_W(OUT_W)) u_ora (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(busy),
    .resp_a(resp_a), .resp_b(resp_b), .mismatch(mismatch), .fail(fail)
  );

  a_r6_clean_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fs_kind == FK_NONE) |-> !mismatch);
  a_r12_unknown_kind_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fs_kind > FK_OPEN) |-> !mismatch);
  a_r11_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> $stable(fs_q));
  a_r3_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
endmodule

// File: tb/sim_twin_cmp_bist.sv
`timescale 1ns/1ps
module sim_twin_cmp_bist;
  localparam int W     = 4;
  localparam int OW    = 3;
  localparam int LW    = 2;
  localparam int FS_W  = 8;
  localparam int N     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [FS_W-1:0] fault_sel = '0;
  logic busy, done, fail;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  twin_cmp_bist #(.PAT_W(W), .OUT_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fault_sel(fault_sel),
    .busy(busy), .done(done), .fail(fail)
  );

  function automatic logic [FS_W-1:0] mk(input logic unit, input int kind, input int a, input int b);
    return {unit, 3'(kind), 2'(a), 2'(b)};
  endfunction

  // independent model of one unit; faulty selects whether the fault applies
  function automatic logic [OW-1:0] model(input logic [W-1:0] p, input logic [FS_W-1:0] fs, input logic faulty);
    logic [W-1:0] drv, tap;
    logic [OW-1:0] o;
    int kind, a, b, ones;
    logic v;
    kind = int'(fs[6:4]); a = int'(fs[3:2]); b = int'(fs[1:0]);
    drv = p; tap = p;
    if (faulty) begin
      if (kind == 1) begin drv[a] = 0; tap[a] = 0; end
      else if (kind == 2) begin drv[a] = 1; tap[a] = 1; end
      else if (kind == 3 && a != b) begin
        v = p[a] & p[b]; drv[a] = v; drv[b] = v; tap[a] = v; tap[b] = v;
      end
      else if (kind == 4) tap[a] = 0;
    end
    ones = 0;
    for (int i = 0; i < W; i++) ones += int'(tap[i]);
    o[0] = ones[0];
    for (int j = 1; j < OW; j++) o[j] = drv[j-1] & drv[j % W];
    return o;
  endfunction

  function automatic int first_bad(input logic [FS_W-1:0] fs);
    for (int p = 0; p < N; p++)
      if (model(4'(p), fs, !fs[7]) != model(4'(p), fs, fs[7])) return p;
    return -1;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // one run; restart_at / change_at are cycle indices (-1 = never)
  task automatic run_case(input string req, input logic [FS_W-1:0] fs,
                          input int restart_at, input int change_at, input logic [FS_W-1:0] fs2);
    int fb;
    fb = first_bad(fs);
    @(negedge clk);
    start = 1'b1; fault_sel = fs;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "busy after start", busy, 1'b1);
    chk("R1", "fail cleared", fail, 1'b0);
    chk("R2", "done after start", done, 1'b0);
    for (int k = 1; k <= N + 1; k++) begin
      start = (k - 1 == restart_at);
      if (k - 1 == change_at) fault_sel = fs2;
      @(negedge clk);
      chk("R2", "busy", busy, k < N);
      chk("R2", "done", done, k == N);
      chk(req, "fail", fail, (fb >= 0) && (k >= fb + 1));
    end
    start = 1'b0;
  endtask

  task automatic test_reset;
    chk("R13", "busy at reset", busy, 1'b0);
    chk("R13", "done at reset", done, 1'b0);
    chk("R13", "fail at reset", fail, 1'b0);
  endtask

  task automatic test_clean;  // R6
    run_case("R6", mk(0, 0, 0, 0), -1, -1, '0);
    run_case("R6", mk(1, 0, 3, 1), -1, -1, '0);
  endtask

  task automatic test_stuck;  // R7, R4 timing of first detection
    run_case("R7", mk(0, 1, 2, 0), -1, -1, '0);
    run_case("R7", mk(0, 2, 0, 0), -1, -1, '0);
    run_case("R4", mk(0, 1, 3, 0), -1, -1, '0);
    run_case("R7", mk(1, 2, 3, 0), -1, -1, '0);
  endtask

  task automatic test_short;  // R8
    run_case("R8", mk(0, 3, 0, 1), -1, -1, '0);
    run_case("R8", mk(1, 3, 1, 3), -1, -1, '0);
  endtask

  task automatic test_open;   // R9
    run_case("R9", mk(0, 4, 1, 0), -1, -1, '0);
    run_case("R9", mk(1, 4, 3, 0), -1, -1, '0);
  endtask

  task automatic test_unit_b; // R10
    run_case("R10", mk(1, 1, 0, 0), -1, -1, '0);
    run_case("R10", mk(1, 3, 2, 0), -1, -1, '0);
  endtask

  task automatic test_restart_ignored; // R3
    run_case("R3", mk(0, 0, 0, 0), 5, -1, '0);
    run_case("R3", mk(0, 1, 3, 0), 12, -1, '0);
  endtask

  task automatic test_capture; // R11: clean run with a fault offered mid-run
    run_case("R11", mk(0, 0, 0, 0), -1, 3, mk(0, 2, 1, 0));
  endtask

  task automatic test_no_fault_codes; // R12
    run_case("R12", mk(0, 5, 1, 0), -1, -1, '0);
    run_case("R12", mk(0, 7, 2, 0), -1, -1, '0);
    run_case("R12", mk(1, 3, 2, 2), -1, -1, '0);
  endtask

  task automatic test_sticky; // R5
    run_case("R5", mk(0, 2, 1, 0), -1, -1, '0);
    repeat (4) @(negedge clk);
    chk("R5", "fail held after done", fail, 1'b1);
    chk("R5", "busy idle after done", busy, 1'b0);
    run_case("R5", mk(0, 0, 0, 0), -1, -1, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_clean();
    test_stuck();
    test_short();
    test_open();
    test_unit_b();
    test_restart_ignored();
    test_capture();
    test_no_fault_codes();
    test_sticky();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule